// File: doc/BRIEF.md
# Serial ADC Interface Sequencer

This block is the digital control side of a 10-bit serial successive-approximation converter. A host runs transfers framed by an active-low select and a serial clock. On each transfer it shifts in a 4-bit channel address and reads back the result of the previous conversion, most significant bit first. The sequencer opens the sampling window of the analog front end partway through the transfer. Once the frame has given enough clock edges, it hands control to a free-running internal oscillator, and that oscillator steps a digital successive-approximation engine fed by an external comparator bit.

The serial clock, select and data inputs are oversampled by the system clock through synchronizer stages. Every action in the frame is therefore keyed to a detected edge count, not to the serial clock itself. The internal oscillator is a tick divided from the system clock. The analog multiplexer, capacitor array and comparator sit outside the block. The block drives the selected address, a sample-enable level and the current trial code to them, and it receives a single comparator decision.

Three address codes run built-in test conversions that ignore the comparator, and the remaining unused codes convert to zero. The frame may be 10 or 16 clocks with select held low, or any length from 10 to 16 with select released between frames.

Top module: `adc_seq`

## Requirements
- R1: Address bits are captured MSB first on the first four detected rising serial-clock edges of a frame and are presented on mux_sel_o.
- R2: While select is high, sdo_oe_o is 0 and the frame counters are cleared. When select goes low, sdo_oe_o becomes 1 and sdo_o carries the MSB of the last stored result. After reset the stored result is 0x000, eoc_o is 1 and sample_en_o is 0.
- R3: Each of the first nine falling serial-clock edges moves sdo_o to the next lower result bit, so all 10 bits appear MSB first. From the tenth falling edge onward sdo_o is 0.
- R4: sample_en_o is 1 from the fourth falling edge of a frame up to the tenth falling edge, and 0 otherwise.
- R5: On the tenth falling edge eoc_o goes to 0 and a conversion starts, with trial_code_o first set to 0x200.
- R6: The conversion makes one decision per internal oscillator tick (one tick every OSC_DIV system clocks). cmp_i = 1 means the input is at or above trial_code_o and keeps the trial bit. After 10 decisions the code is stored as the next result and eoc_o returns to 1.
- R7: Addresses 0x0 to 0x4 convert using cmp_i.
- R8: Address 0xB yields 0x200, 0xC yields 0x000 and 0xD yields 0x3FF, whatever cmp_i does.
- R9: Addresses 0x5 to 0xA, 0xE and 0xF yield 0x000.
- R10: With select held low, if no rising serial-clock edge arrives between the tenth falling edge and the end of the conversion, a new frame begins when the conversion ends, and sdo_o presents the MSB of the new result.
- R11: With select held low, if a rising edge does arrive during the conversion, the frame runs to its sixteenth falling edge, and the new frame begins there or at the end of the conversion, whichever is later.
- R12: A 16-clock host that pauses the serial clock until the conversion ends loses frame alignment: its 11th to 16th clocks act as the first clocks of a new frame. Releasing select and selecting again restores alignment.
- R13: With select released between frames, any frame length from 10 to 16 clocks gives a correct result on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs and to derive the oscillator tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host; each level must last at least SYNC_STAGES+2 system clocks |
| cs_n_i | input | 1 | Active-low select from the host |
| sdi_i | input | 1 | Serial address input, MSB first |
| cmp_i | input | 1 | Comparator decision: 1 when the sampled input is at or above trial_code_o |
| sdo_o | output | 1 | Serial result output, MSB first |
| sdo_oe_o | output | 1 | Output enable for the serial result pad |
| sample_en_o | output | 1 | Sampling window for the analog front end |
| eoc_o | output | 1 | End-of-conversion flag, low while converting |
| mux_sel_o | output | 4 | Captured channel address |
| trial_code_o | output | RES_BITS | Trial code presented to the capacitor array |

## Verification
The bench builds the block with its defaults: RES_BITS 10, OSC_DIV 4 and two synchronizer stages. With these, a conversion lasts about 44 system clocks, while each serial clock lasts 16. That lets the bench place a frame's remaining clocks either inside the conversion or after it, which brings both the 16-clock continuation and the lost-alignment case within reach. A behavioural comparator turns a per-vector input level into cmp_i, so normal channels must reproduce that level and the test addresses must ignore it.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    MODE_CMP  = 2'd0,
    MODE_HALF = 2'd1,
    MODE_ZERO = 2'd2,
    MODE_FULL = 2'd3
  } conv_mode_e;

  // Channel codes 0..4 use the comparator; B/C/D are built-in tests; the rest read zero.
  function automatic conv_mode_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4: return MODE_CMP;
      4'hB:                         return MODE_HALF;
      4'hD:                         return MODE_FULL;
      default:                      return MODE_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
module adc_seq_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);

  logic [STAGES:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign lvl_o = pipe_q[STAGES-1];
  assign chg_o = pipe_q[STAGES-1] ^ pipe_q[STAGES];

endmodule

// File: rtl/adc_seq_sar.sv
`timescale 1ns/1ps
module adc_seq_sar
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int OSC_DIV  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  conv_mode_e          mode_i,
  input  logic                cmp_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] code_o
);

  localparam int                OW       = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [OW-1:0]     OSC_LAST = OW'(OSC_DIV - 1);
  localparam logic [RES_BITS-1:0] MSB    = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [OW-1:0]       osc_q, osc_d;
  logic                osc_tick;
  logic [RES_BITS-1:0] code_q, code_d, step_q, step_d;
  logic                busy_q, busy_d, done_q, done_d, keep;
  conv_mode_e          mode_q, mode_d;

  // free-running internal oscillator, modelled as a divided tick
  assign osc_tick = (osc_q == OSC_LAST);
  assign osc_d    = osc_tick ? '0 : osc_q + 1'b1;

  always_comb begin
    case (mode_q)
      MODE_CMP:  keep = cmp_i;
      MODE_HALF: keep = step_q[RES_BITS-1];
      MODE_FULL: keep = 1'b1;
      default:   keep = 1'b0;
    endcase
  end

  always_comb begin
    code_d = code_q;
    step_d = step_q;
    busy_d = busy_q;
    mode_d = mode_q;
    done_d = 1'b0;
    if (start_i) begin
      code_d = MSB;
      step_d = MSB;
      busy_d = 1'b1;
      mode_d = mode_i;
    end else if (busy_q && osc_tick) begin
      code_d = (code_q & ~step_q) | (keep ? step_q : '0) | (step_q >> 1);
      step_d = step_q >> 1;
      if (step_q[0]) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q  <= '0;
      code_q <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= MODE_CMP;
    end else begin
      osc_q  <= osc_d;
      code_q <= code_d;
      step_q <= step_d;
      busy_q <= busy_d;
      done_q <= done_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign code_o = code_q;

  a_r5_trial_starts_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (code_o == MSB));
  a_r6_single_active_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $onehot(step_q));
  a_r8_full_scale_test: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == MODE_FULL) |-> (&code_q));
  a_r9_zero_mode_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == MODE_ZERO) |-> (code_q == '0));

endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int OSC_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_FRAME = 10,
  parameter int LONG_FRAME  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_i,
  input  logic                cs_n_i,
  input  logic                sdi_i,
  input  logic                cmp_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic                sample_en_o,
  output logic                eoc_o,
  output logic [ADDR_W-1:0]   mux_sel_o,
  output logic [RES_BITS-1:0] trial_code_o
);

  localparam int            CW      = $clog2(LONG_FRAME + 1);
  localparam int            RW      = $clog2(ADDR_W + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_FRAME);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_FRAME);
  localparam logic [CW-1:0] SAMP_C  = CW'(ADDR_W);
  localparam logic [RW-1:0] ADDR_C  = RW'(ADDR_W);

  // synchronized serial inputs: bit 1 = select (active low), bit 0 = serial clock
  logic [1:0]             in_lvl, in_chg;
  logic [SYNC_STAGES-1:0] sdi_pipe_q;
  logic                   sclk_rise, sclk_fall, cs_lo, cs_act, sdi_s;

  adc_seq_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_n_i, sclk_i}),
    .lvl_o (in_lvl),
    .chg_o (in_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdi_pipe_q <= '0;
    else        sdi_pipe_q <= {sdi_pipe_q[SYNC_STAGES-2:0], sdi_i};
  end

  assign sdi_s     = sdi_pipe_q[SYNC_STAGES-1];
  assign sclk_rise = in_chg[0] &  in_lvl[0];
  assign sclk_fall = in_chg[0] & ~in_lvl[0];
  assign cs_lo     = ~in_lvl[1];
  assign cs_act    = in_chg[1] & ~in_lvl[1];

  // frame state
  logic [CW-1:0]       fall_q, fall_d;
  logic [RW-1:0]       rise_q, rise_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [RES_BITS-1:0] shift_q, shift_d, result_q, result_d, load_val;
  logic                oe_q, oe_d, samp_q, samp_d, long_q, long_d, eoc_q, eoc_d;
  logic                conv_go, restart;
  logic                sar_busy, sar_done;
  logic [RES_BITS-1:0] sar_code;

  adc_seq_sar #(.RES_BITS(RES_BITS), .OSC_DIV(OSC_DIV)) u_sar (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (conv_go),
    .mode_i  (decode_addr(addr_q)),
    .cmp_i   (cmp_i),
    .busy_o  (sar_busy),
    .done_o  (sar_done),
    .code_o  (sar_code)
  );

  // a frame with select held low ends at the short count unless a rising edge
  // came during the conversion, in which case it runs to the long count
  assign restart  = cs_lo && !sar_busy &&
                    (((fall_q == SHORT_C) && !long_q) || (fall_q == LONG_C));
  assign load_val = sar_done ? sar_code : result_q;

  always_comb begin
    fall_d   = fall_q;
    rise_d   = rise_q;
    addr_d   = addr_q;
    shift_d  = shift_q;
    oe_d     = oe_q;
    samp_d   = samp_q;
    long_d   = long_q;
    eoc_d    = eoc_q;
    result_d = result_q;
    conv_go  = 1'b0;
    if (sar_done) begin
      result_d = sar_code;
      eoc_d    = 1'b1;
    end
    if (!cs_lo) begin
      fall_d = '0;
      rise_d = '0;
      oe_d   = 1'b0;
      samp_d = 1'b0;
      long_d = 1'b0;
    end else if (cs_act || restart) begin
      fall_d  = '0;
      rise_d  = '0;
      oe_d    = 1'b1;
      samp_d  = 1'b0;
      long_d  = 1'b0;
      shift_d = load_val;
    end else begin
      if (sclk_rise) begin
        if (rise_q < ADDR_C) begin
          addr_d = {addr_q[ADDR_W-2:0], sdi_s};
          rise_d = rise_q + 1'b1;
        end
        if ((fall_q >= SHORT_C) && sar_busy) long_d = 1'b1;
      end
      if (sclk_fall && (fall_q != LONG_C)) begin
        fall_d  = fall_q + 1'b1;
        shift_d = {shift_q[RES_BITS-2:0], 1'b0};
        if (fall_d == SAMP_C) samp_d = 1'b1;
        if (fall_d == SHORT_C) begin
          samp_d  = 1'b0;
          eoc_d   = 1'b0;
          conv_go = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q   <= '0;
      rise_q   <= '0;
      addr_q   <= '0;
      shift_q  <= '0;
      result_q <= '0;
      oe_q     <= 1'b0;
      samp_q   <= 1'b0;
      long_q   <= 1'b0;
      eoc_q    <= 1'b1;
    end else begin
      fall_q   <= fall_d;
      rise_q   <= rise_d;
      addr_q   <= addr_d;
      shift_q  <= shift_d;
      result_q <= result_d;
      oe_q     <= oe_d;
      samp_q   <= samp_d;
      long_q   <= long_d;
      eoc_q    <= eoc_d;
    end
  end

  assign sdo_o        = shift_q[RES_BITS-1];
  assign sdo_oe_o     = oe_q;
  assign sample_en_o  = samp_q;
  assign eoc_o        = eoc_q;
  assign mux_sel_o    = addr_q;
  assign trial_code_o = sar_code;

  a_r2_release_disables_output: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lo |=> !sdo_oe_o);
  a_r3_shift_holds_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo && !sclk_fall && !cs_act && !restart) |=> $stable(shift_q));
  a_r4_window_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> ((fall_q >= SAMP_C) && (fall_q < SHORT_C)));
  a_r5_eoc_drop_starts_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_o) |-> sar_busy);
  a_r6_eoc_rise_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_o) |-> (!sar_busy && (result_q == $past(sar_code))));

endmodule

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;

  localparam int H = 8;  // system clocks per serial clock half period

  logic       clk = 1'b0;
  logic       rst_n, sclk_b, cs_n_b, sdi_b, cmp_b;
  logic       sdo, sdo_oe, samp, eoc;
  logic [3:0] mux_sel;
  logic [9:0] trial, vin;

  int checks = 0;
  int fails  = 0;

  logic [16:0] sdo_log, samp_log;

  always #2.5 clk = ~clk;

  // behavioural comparator: 1 when the analog level is at or above the trial code
  always_comb cmp_b = (vin >= trial);

  adc_seq u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_i       (sclk_b),
    .cs_n_i       (cs_n_b),
    .sdi_i        (sdi_b),
    .cmp_i        (cmp_b),
    .sdo_o        (sdo),
    .sdo_oe_o     (sdo_oe),
    .sample_en_o  (samp),
    .eoc_o        (eoc),
    .mux_sel_o    (mux_sel),
    .trial_code_o (trial)
  );

  // {address, analog level, expected result}
  localparam logic [23:0] VEC [12] = '{
    {4'h0, 10'h155, 10'h155},
    {4'h1, 10'h3FF, 10'h3FF},
    {4'h2, 10'h000, 10'h000},
    {4'h3, 10'h200, 10'h200},
    {4'h4, 10'h1AB, 10'h1AB},
    {4'hB, 10'h123, 10'h200},
    {4'hC, 10'h3F0, 10'h000},
    {4'hD, 10'h005, 10'h3FF},
    {4'h5, 10'h2F0, 10'h000},
    {4'hA, 10'h3FF, 10'h000},
    {4'hE, 10'h100, 10'h000},
    {4'hF, 10'h311, 10'h000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_clocks(input logic [3:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      sdi_b = (k < 4) ? a[3-k] : 1'b0;
      wait_cyc(H);
      sdo_log[k]  = sdo;
      samp_log[k] = samp;
      sclk_b = 1'b1;
      wait_cyc(H);
      sclk_b = 1'b0;
    end
    wait_cyc(H);
    sdo_log[n]  = sdo;
    samp_log[n] = samp;
  endtask

  function automatic logic [9:0] got_word();
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[9-i] = sdo_log[i];
    return w;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a <= 4'h4)                   return "R7 channel result";
    if (a >= 4'hB && a <= 4'hD)      return "R8 self-test result";
    return "R9 reserved result";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] prev_exp;
    string      prev_tag;
    rst_n = 1'b0; sclk_b = 1'b0; cs_n_b = 1'b1; sdi_b = 1'b0; vin = '0;
    sdo_log = '0; samp_log = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);

    // R2 reset state
    chk("R2 reset oe", int'(sdo_oe), 0);
    chk("R2 reset eoc", int'(eoc), 1);
    chk("R2 reset sample_en", int'(samp), 0);

    // vector walk, select released between frames (R1, R3-R9)
    prev_exp = 10'h000;
    prev_tag = "R2 reset result";
    for (int i = 0; i < 12; i++) begin
      logic [3:0] a;
      logic [9:0] v, e;
      {a, v, e} = VEC[i];
      vin    = v;
      cs_n_b = 1'b0;
      run_clocks(a, 10);
      chk(prev_tag, int'(got_word()), int'(prev_exp));
      chk("R1 captured address", int'(mux_sel), int'(a));
      chk("R5 eoc low during conversion", int'(eoc), 0);
      chk("R2 oe while selected", int'(sdo_oe), 1);
      if (i == 0) begin
        chk("R4 window closed before 4th fall", int'(samp_log[3]), 0);
        chk("R4 window open at 4th fall", int'(samp_log[4]), 1);
        chk("R4 window open at 9th fall", int'(samp_log[9]), 1);
        chk("R4 window closed at 10th fall", int'(samp_log[10]), 0);
        chk("R3 sdo zero after 10th fall", int'(sdo_log[10]), 0);
      end
      cs_n_b = 1'b1;
      wait_cyc(60);
      chk("R6 eoc high after conversion", int'(eoc), 1);
      chk("R2 oe off when released", int'(sdo_oe), 0);
      prev_exp = e;
      prev_tag = tag_of(a);
    end
    cs_n_b = 1'b0;
    vin    = 10'h0F0;
    run_clocks(4'h1, 13);   // R13: 13-clock frame
    chk(prev_tag, int'(got_word()), int'(prev_exp));
    chk("R3 sdo zero in frame tail", int'(sdo_log[10] | sdo_log[11] | sdo_log[12]), 0);
    cs_n_b = 1'b1;
    wait_cyc(60);
    cs_n_b = 1'b0;
    run_clocks(4'h0, 10);
    chk("R13 result after 13-clock frame", int'(got_word()), 'h0F0);
    cs_n_b = 1'b1;
    wait_cyc(60);

    // R10: select held low, 10-clock frames
    cs_n_b = 1'b0;
    vin    = 10'h2AA;
    run_clocks(4'h2, 10);
    wait_cyc(80);
    chk("R10 eoc high before next frame", int'(eoc), 1);
    vin = 10'h0C3;
    run_clocks(4'h3, 10);
    chk("R10 back-to-back short frame", int'(got_word()), 'h2AA);
    wait_cyc(80);
    run_clocks(4'h0, 10);
    chk("R10 second back-to-back frame", int'(got_word()), 'h0C3);
    cs_n_b = 1'b1;
    wait_cyc(60);

    // R11: select held low, 16-clock frames
    cs_n_b = 1'b0;
    vin    = 10'h155;
    run_clocks(4'h4, 16);
    chk("R3 sdo zero across clocks 11-16",
        int'(|{sdo_log[15], sdo_log[14], sdo_log[13], sdo_log[12], sdo_log[11], sdo_log[10]}), 0);
    chk("R11 conversion done inside frame", int'(eoc), 1);
    vin = 10'h0AB;
    run_clocks(4'h0, 16);
    chk("R11 back-to-back long frame", int'(got_word()), 'h155);
    cs_n_b = 1'b1;
    wait_cyc(60);
    cs_n_b = 1'b0;
    run_clocks(4'h0, 10);
    chk("R11 result of second long frame", int'(got_word()), 'h0AB);
    cs_n_b = 1'b1;
    wait_cyc(60);

    // R12: serial clock paused through the conversion of a 16-clock frame
    cs_n_b = 1'b0;
    vin    = 10'h300;
    run_clocks(4'h1, 10);
    wait_cyc(100);
    run_clocks(4'h0, 6);
    chk("R12 clock 11 sees new frame MSB", int'(sdo_log[0]), 1);
    chk("R12 clock 14 opens new window", int'(samp_log[4]), 1);
    cs_n_b = 1'b1;
    wait_cyc(8);
    chk("R12 release disables output", int'(sdo_oe), 0);
    wait_cyc(60);
    cs_n_b = 1'b0;
    run_clocks(4'h0, 10);
    chk("R12 alignment restored by select toggle", int'(got_word()), 'h300);
    cs_n_b = 1'b1;
    wait_cyc(60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule